// File: doc/BRIEF.md
# Serial EEPROM Block Transfer Sequencer

This engine moves a block of bytes between a byte stream and a serial EEPROM that takes a 16-bit address. A request is a single start pulse with a start address, a byte count and a direction. The engine breaks the request into pieces of at most `CHUNK` bytes and issues one framed command per piece. Each piece moves the address on by its own length, and the address wraps at 16 bits. The SPI shifter sits outside the block. The engine reaches it through a byte handshake: a request with a transmit byte goes out, and an acknowledge with the received byte comes back. A frame-select output stays high for the duration of each frame.

On reads, one frame per piece carries the read opcode, the two address bytes and one filler byte per data byte. The bytes received after the first three go out on the read stream. On writes, each piece is sent as a one-byte write-enable frame followed by the write frame. Write data is taken from the input stream one byte per acknowledge. After each write frame the engine polls the device status, waiting one millisecond between polls, until the device reports ready. If the device is still busy after `POLL_MAX` polls, the engine raises a timeout error, drops the remaining pieces and finishes.

Top module: `eeprom_seq`

## Requirements
- R1: A start with a byte count of 0 raises `done` in the cycle after the start. `spi_cs` never goes high for that request.
- R2: A read piece is a single frame. Its bytes are opcode 0x03, address high byte, address low byte and then N filler bytes of 0x00. The received bytes from the fourth onward appear on `rd_byte` with one `rd_valid` pulse each, in order.
- R3: A request is split into pieces of min(remaining, `CHUNK`) bytes. The address of each piece is the previous address plus the previous piece length, modulo 2^16. `spi_cs` is low for at least one cycle between frames.
- R4: Each write piece has two frames. The first is a one-byte frame carrying 0x06. The second carries 0x02, the address high and low bytes, and the data bytes. `wr_take` pulses once per data byte, on that byte's acknowledge.
- R5: After every write frame the engine sends two-byte status frames of 0x05 then 0x00. It moves to the next piece once bit 0 of the second received byte is 0.
- R6: After a status frame that reports busy, the next status frame starts no sooner than `CLK_KHZ` cycles later.
- R7: If `POLL_MAX` status frames in a row report busy, `timeout_err` rises together with `done`, and no further frame is issued. The next start clears `timeout_err`.
- R8: After reset, `busy`, `done`, `spi_cs` and `timeout_err` are 0. `done` is a one-cycle pulse, and `busy` is low in the cycle `done` is high.
- R9: While `spi_req` is high and `spi_ack` is low, `spi_req` stays high in the next cycle and `spi_tx` does not change.
- R10: A start pulse while `busy` is high has no effect on the frames issued or on the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse, accepted when idle |
| dir_write | input | 1 | 1 = write to EEPROM, 0 = read |
| start_addr | input | 16 | First byte address |
| byte_count | input | CNT_W | Number of bytes to move |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Set when status polling ran out; cleared on start |
| wr_byte | input | 8 | Current write-stream byte |
| wr_take | output | 1 | Write-stream byte consumed this cycle |
| rd_byte | output | 8 | Read-stream byte |
| rd_valid | output | 1 | `rd_byte` valid this cycle |
| spi_cs | output | 1 | Frame select, high for a whole frame |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Byte transfer complete, `spi_rx` valid |
| spi_rx | input | 8 | Byte shifted in |

## Verification
A wrong byte index or frame kind shows up on `spi_tx` within the same frame, as a bad opcode, a misplaced address byte or a wrong frame length. A device model that logs every frame therefore exposes it as soon as `spi_cs` falls. A chunk tracker that holds a wrong count or address shows up in the next frame's address bytes, or as an early or late `done`. A poll counter or interval timer that is off shows up as the wrong number of status frames before `timeout_err`, or as poll starts spaced too close together.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    localparam int IDX_W = 8;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_WRITE,
        FR_READ,
        FR_STAT
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP,
        ST_WAIT
    } state_e;

    typedef struct packed {
        frame_e           kind;
        logic [IDX_W-1:0] idx;
    } frame_pos_t;

    function automatic logic [7:0] opcode_of(frame_e k);
        case (k)
            FR_WREN:  return OP_WREN;
            FR_WRITE: return OP_WRITE;
            FR_READ:  return OP_READ;
            default:  return OP_RDSR;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] frame_len(frame_e k, logic [IDX_W-1:0] n);
        case (k)
            FR_WREN: return IDX_W'(1);
            FR_STAT: return IDX_W'(2);
            default: return IDX_W'(3) + n;
        endcase
    endfunction

    function automatic logic [7:0] frame_tx(frame_pos_t p, logic [15:0] a, logic [7:0] wd);
        if (p.idx == '0)           return opcode_of(p.kind);
        if (p.kind == FR_STAT)     return 8'h00;
        if (p.idx == IDX_W'(1))    return a[15:8];
        if (p.idx == IDX_W'(2))    return a[7:0];
        if (p.kind == FR_WRITE)    return wd;
        return 8'h00;
    endfunction

endpackage

// File: rtl/eeprom_seq_chunker.sv
module eeprom_seq_chunker #(
    parameter int CNT_W = 16,
    parameter int CHUNK = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [15:0]      load_addr,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             step,
    output logic [15:0]      addr,
    output logic [CNT_W-1:0] cur_len,
    output logic             last
);
    localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK);

    logic [CNT_W-1:0] remain;

    assign cur_len = (remain > CHUNK_C) ? CHUNK_C : remain;
    assign last    = (remain <= CHUNK_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= load_addr;
            remain <= load_cnt;
        end else if (step) begin
            addr   <= addr + 16'(cur_len);
            remain <= remain - cur_len;
        end
    end
endmodule

// File: rtl/eeprom_seq_timer.sv
module eeprom_seq_timer #(
    parameter int PERIOD = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt;

    assign expire = run && (cnt == W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || expire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
    import eeprom_seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int CHUNK    = 16,
    parameter int CLK_KHZ  = 125000,
    parameter int POLL_MAX = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir_write,
    input  logic [15:0]      start_addr,
    input  logic [CNT_W-1:0] byte_count,
    output logic             busy,
    output logic             done,
    output logic             timeout_err,
    input  logic [7:0]       wr_byte,
    output logic             wr_take,
    output logic [7:0]       rd_byte,
    output logic             rd_valid,
    output logic             spi_cs,
    output logic             spi_req,
    output logic [7:0]       spi_tx,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rx
);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(3);

    state_e           state;
    frame_pos_t       pos;
    logic [PW-1:0]    polls;
    logic             dev_busy;
    logic             dir_q;

    logic [15:0]      cur_addr;
    logic [CNT_W-1:0] cur_len;
    logic             last_chunk;
    logic             load, step, tick;
    logic             byte_done, frame_end;
    logic [IDX_W-1:0] flen;
    frame_e           first_kind;

    assign flen       = frame_len(pos.kind, IDX_W'(cur_len));
    assign byte_done  = (state == ST_XFER) && spi_ack;
    assign frame_end  = byte_done && (pos.idx == flen - 1'b1);
    assign first_kind = dir_q ? FR_WREN : FR_READ;
    assign load       = (state == ST_IDLE) && start && (byte_count != '0);
    assign step       = (state == ST_GAP) &&
                        ((pos.kind == FR_READ) || (pos.kind == FR_STAT && !dev_busy));

    eeprom_seq_chunker #(.CNT_W(CNT_W), .CHUNK(CHUNK)) u_chunk (
        .clk(clk), .rst(rst), .load(load), .load_addr(start_addr),
        .load_cnt(byte_count), .step(step), .addr(cur_addr),
        .cur_len(cur_len), .last(last_chunk)
    );

    eeprom_seq_timer #(.PERIOD(CLK_KHZ)) u_timer (
        .clk(clk), .rst(rst), .run(state == ST_WAIT), .expire(tick)
    );

    assign busy    = (state != ST_IDLE);
    assign spi_cs  = (state == ST_XFER);
    assign spi_req = (state == ST_XFER);
    assign spi_tx  = frame_tx(pos, cur_addr, wr_byte);
    assign wr_take = byte_done && (pos.kind == FR_WRITE) && (pos.idx >= DATA_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            pos         <= '{kind: FR_READ, idx: '0};
            polls       <= '0;
            dev_busy    <= 1'b0;
            dir_q       <= 1'b0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            rd_byte     <= '0;
            rd_valid    <= 1'b0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    timeout_err <= 1'b0;
                    if (byte_count == '0) begin
                        done <= 1'b1;
                    end else begin
                        dir_q <= dir_write;
                        pos   <= '{kind: (dir_write ? FR_WREN : FR_READ), idx: '0};
                        state <= ST_XFER;
                    end
                end
                ST_XFER: if (spi_ack) begin
                    if (pos.kind == FR_READ && pos.idx >= DATA_IDX) begin
                        rd_byte  <= spi_rx;
                        rd_valid <= 1'b1;
                    end
                    if (pos.kind == FR_STAT && pos.idx == IDX_W'(1))
                        dev_busy <= spi_rx[0];
                    if (frame_end) state   <= ST_GAP;
                    else           pos.idx <= pos.idx + 1'b1;
                end
                ST_GAP: begin
                    case (pos.kind)
                        FR_WREN: begin
                            pos   <= '{kind: FR_WRITE, idx: '0};
                            state <= ST_XFER;
                        end
                        FR_WRITE: begin
                            pos   <= '{kind: FR_STAT, idx: '0};
                            polls <= '0;
                            state <= ST_XFER;
                        end
                        FR_STAT: begin
                            if (!dev_busy) begin
                                if (last_chunk) begin
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end else begin
                                    pos   <= '{kind: first_kind, idx: '0};
                                    state <= ST_XFER;
                                end
                            end else if (polls == PW'(POLL_MAX - 1)) begin
                                timeout_err <= 1'b1;
                                done        <= 1'b1;
                                state       <= ST_IDLE;
                            end else begin
                                polls <= polls + 1'b1;
                                state <= ST_WAIT;
                            end
                        end
                        default: begin
                            if (last_chunk) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                pos   <= '{kind: first_kind, idx: '0};
                                state <= ST_XFER;
                            end
                        end
                    endcase
                end
                ST_WAIT: if (tick) begin
                    pos   <= '{kind: FR_STAT, idx: '0};
                    state <= ST_XFER;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       timeout_err,
    input logic       wr_take,
    input logic       rd_valid,
    input logic       spi_cs,
    input logic       spi_req,
    input logic [7:0] spi_tx,
    input logic       spi_ack
);
    AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_cs);                                            // R1
    AST_RD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(spi_ack && spi_cs));                        // R2
    AST_TAKE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> (spi_ack && spi_cs));                              // R4
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> done);                                  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                               // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));       // R9
endmodule

bind eeprom_seq eeprom_seq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .timeout_err(timeout_err), .wr_take(wr_take), .rd_valid(rd_valid),
    .spi_cs(spi_cs), .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack)
);

// File: tb/eeprom_seq_test.sv
`timescale 1ns/1ps
module eeprom_seq_test;
    localparam int MS   = 10;
    localparam int PMAX = 4;

    logic        clk = 0, rst = 1;
    logic        start = 0, dir_write = 0;
    logic [15:0] start_addr = 0, byte_count = 0;
    logic        busy, done, timeout_err, wr_take, rd_valid;
    logic [7:0]  wr_byte, rd_byte, spi_tx;
    logic        spi_cs, spi_req;
    logic        spi_ack = 0;
    logic [7:0]  spi_rx = 0;

    always #4 clk = ~clk;

    eeprom_seq #(.CNT_W(16), .CHUNK(16), .CLK_KHZ(MS), .POLL_MAX(PMAX)) uut (
        .clk(clk), .rst(rst), .start(start), .dir_write(dir_write),
        .start_addr(start_addr), .byte_count(byte_count), .busy(busy),
        .done(done), .timeout_err(timeout_err), .wr_byte(wr_byte),
        .wr_take(wr_take), .rd_byte(rd_byte), .rd_valid(rd_valid),
        .spi_cs(spi_cs), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // write stream source
    logic [7:0] src [64];
    int src_ptr = 0;
    assign wr_byte = src[src_ptr[5:0]];
    always @(posedge clk) if (wr_take) src_ptr <= src_ptr + 1;

    // read stream sink
    logic [7:0] rd_buf [64];
    int rd_n = 0;
    always @(negedge clk) if (rd_valid) begin
        if (rd_n < 64) rd_buf[rd_n] = rd_byte;
        rd_n++;
    end

    // device model and frame log
    logic [7:0]  mem [256];
    int          busy_cfg = 0, busy_left = 0;
    int          f_idx = 0, f_start = 0;
    logic [7:0]  cur_op = 0, a_hi = 0, a_lo = 0, tx_first = 0;
    logic [15:0] m_addr = 0;
    bit          pend = 0;
    int          tx_glitch = 0;
    int          nf = 0;
    logic [7:0]  log_op [64];
    int          log_len [64];
    logic [15:0] log_addr [64];
    int          log_t [64];

    always @(negedge clk) begin
        if (rst || !spi_cs) begin
            if (f_idx > 0 && nf < 64) begin
                log_op[nf] = cur_op; log_len[nf] = f_idx;
                log_addr[nf] = {a_hi, a_lo}; log_t[nf] = f_start;
            end
            if (f_idx > 0) nf++;
            f_idx = 0; pend = 0; spi_ack = 0;
        end else if (spi_ack) begin
            spi_ack = 0;
        end else if (spi_req && !pend) begin
            pend = 1; tx_first = spi_tx;
        end else if (spi_req) begin
            pend = 0;
            if (spi_tx != tx_first) tx_glitch++;
            spi_rx = 8'hFF;
            if (f_idx == 0) begin
                cur_op = spi_tx; f_start = cyc;
            end else if (f_idx == 1) begin
                if (cur_op == 8'h05) begin
                    spi_rx = {7'b0, busy_left > 0};
                    if (busy_left > 0) busy_left--;
                end else a_hi = spi_tx;
            end else if (f_idx == 2) begin
                a_lo = spi_tx; m_addr = {a_hi, spi_tx};
            end else begin
                if (cur_op == 8'h03) spi_rx = mem[m_addr[7:0]];
                if (cur_op == 8'h02) begin
                    mem[m_addr[7:0]] = spi_tx; busy_left = busy_cfg;
                end
                m_addr++;
            end
            f_idx++;
            spi_ack = 1;
        end
    end

    // expected frame list
    logic [7:0]  exp_op [64];
    int          exp_len [64];
    logic [15:0] exp_addr [64];
    int          ne = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
        summary();
    end

    task automatic add_exp(logic [7:0] op, int len, logic [15:0] a);
        exp_op[ne] = op; exp_len[ne] = len; exp_addr[ne] = a; ne++;
    endtask

    task automatic kick(bit wr, logic [15:0] a, int n);
        nf = 0; rd_n = 0; src_ptr = 0; ne = 0; tx_glitch = 0;
        @(negedge clk);
        start = 1; dir_write = wr; start_addr = a; byte_count = 16'(n);
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(string req);
        while (!done) @(negedge clk);
        check(busy == 0, req, "busy low with done", busy, 0);
        @(negedge clk);
        check(done == 0, req, "done one cycle", done, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_frames(string req);
        check(nf == ne, req, "frame count", nf, ne);
        for (int i = 0; i < ne && i < nf; i++) begin
            check(log_op[i] == exp_op[i], req, $sformatf("frame %0d opcode", i), log_op[i], exp_op[i]);
            check(log_len[i] == exp_len[i], req, $sformatf("frame %0d length", i), log_len[i], exp_len[i]);
            if (exp_op[i] == 8'h02 || exp_op[i] == 8'h03)
                check(log_addr[i] == exp_addr[i], req, $sformatf("frame %0d address", i),
                      log_addr[i], exp_addr[i]);
        end
        check(tx_glitch == 0, "R9", "tx changed before ack", tx_glitch, 0);
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0 && spi_cs == 0 && timeout_err == 0, "R8",
              "reset outputs", {busy, done, spi_cs, timeout_err}, 0);
    endtask

    task automatic t_zero();
        kick(0, 16'h0010, 0);
        check(done == 1, "R1", "done after zero count", done, 1);
        repeat (5) @(negedge clk);
        check(nf == 0, "R1", "no frame for zero count", nf, 0);
    endtask

    task automatic t_read(logic [15:0] a, int n, string req);
        int rem = n;
        logic [15:0] ca = a;
        kick(0, a, n);
        wait_done(req);
        while (rem > 0) begin
            int l = (rem > 16) ? 16 : rem;
            add_exp(8'h03, 3 + l, ca);
            ca += 16'(l); rem -= l;
        end
        compare_frames(req);
        check(rd_n == n, "R2", "read byte count", rd_n, n);
        for (int i = 0; i < n && i < 64; i++)
            check(rd_buf[i] == mem[8'(a + 16'(i))], "R2", $sformatf("read byte %0d", i),
                  rd_buf[i], mem[8'(a + 16'(i))]);
    endtask

    task automatic t_write(logic [15:0] a, int n, int bcfg, bit expect_to, string req);
        int rem = n;
        logic [15:0] ca = a;
        bit stop = 0;
        busy_cfg = bcfg; busy_left = 0;
        for (int i = 0; i < 64; i++) src[i] = 8'(8'hA0 + i);
        kick(1, a, n);
        wait_done(req);
        while (rem > 0 && !stop) begin
            int l = (rem > 16) ? 16 : rem;
            add_exp(8'h06, 1, 0);
            add_exp(8'h02, 3 + l, ca);
            if (bcfg + 1 <= PMAX) begin
                for (int k = 0; k <= bcfg; k++) add_exp(8'h05, 2, 0);
            end else begin
                for (int k = 0; k < PMAX; k++) add_exp(8'h05, 2, 0);
                stop = 1;
            end
            ca += 16'(l); rem -= l;
        end
        compare_frames(req);
        check(timeout_err == expect_to, "R7", "timeout flag", timeout_err, expect_to);
        if (!expect_to) begin
            check(src_ptr == n, "R4", "bytes taken", src_ptr, n);
            for (int i = 0; i < n; i++)
                check(mem[8'(a + 16'(i))] == src[i], "R4", $sformatf("written byte %0d", i),
                      mem[8'(a + 16'(i))], src[i]);
        end
        for (int i = 1; i < nf && i < 64; i++)
            if (log_op[i] == 8'h05 && log_op[i-1] == 8'h05)
                check(log_t[i] - log_t[i-1] >= MS, "R6", "poll spacing",
                      log_t[i] - log_t[i-1], MS);
    endtask

    task automatic t_ignore();
        logic [7:0] keep = mem[8'h80];
        kick(0, 16'h0020, 4);
        repeat (3) @(negedge clk);
        start = 1; dir_write = 1; start_addr = 16'h0080; byte_count = 16'd3;
        @(negedge clk);
        start = 0;
        wait_done("R10");
        check(nf == 1, "R10", "frames after ignored start", nf, 1);
        check(log_op[0] == 8'h03, "R10", "only read frame", log_op[0], 8'h03);
        check(mem[8'h80] == keep, "R10", "memory untouched", mem[8'h80], keep);
        check(rd_n == 4, "R10", "read count", rd_n, 4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 5);
        for (int i = 0; i < 64; i++) src[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_zero();
        t_read(16'h0123, 5, "R2");
        t_read(16'hFFF8, 37, "R3");
        t_write(16'h0040, 20, 2, 0, "R5");
        t_write(16'h0090, 20, 100, 1, "R7");
        repeat (30) @(negedge clk);
        check(nf == 2 + PMAX, "R7", "no frames after timeout", nf, 2 + PMAX);
        t_read(16'h0005, 2, "R7");
        check(timeout_err == 0, "R7", "flag cleared by start", timeout_err, 0);
        t_ignore();
        summary();
    end
endmodule